// File: doc/BRIEF.md
# SPI Master on Remappable GPIO Lines

This block is a register-programmed SPI master whose four serial signals do not have fixed pins. The clock, data-out, data-in and chip-select lines are placed at run time onto any lines of a general-purpose I/O bank. Software fills a small table of peripheral setups. Each setup names the four pin indices, the transfer length and the clock edges that launch and capture data.

A transaction register selects one setup and sets the clock divider. One write to the data register starts the transfer. While the transfer runs, the block drives only the pins named by the selected setup. A status register returns the captured bits and a ready flag.

The pad drivers and any sharing of the bank with other users sit outside the block. The block only produces per-line output values and output enables, and it reads the per-line input values.

Top module: `gpio_spi_master`

## Requirements
- R1: Setup slot k is at byte offset 4*k (k = 0..3) and reads back bits [27:0] as written with [31:28] zero. The transaction register at 0x10 reads back bits [17:0] as written with [31:18] zero.
- R2: After reset, the status register at 0x18 reads 0x0100_0000 (ready in bit 24, response [23:0] zero). Bits [31:25] always read zero.
- R3: A write to 0x14 while ready is set, with a nonzero length in the selected setup, starts a transfer. Ready then stays low for exactly (2L+1)*(D+1) clock cycles, where L is the length and D is the divider.
- R4: The serial clock idles low. It toggles once every D+1 cycles and gives exactly L rising edges per transfer.
- R5: Outgoing data is sent MSB first, starting at bit L-1 of the written word (zeros first when L > 32). Setup bit 27 selects the launch edge: 0 means data changes on falling edges, 1 means data changes on rising edges after the first one. In both cases the first bit is presented at the start of the transfer.
- R6: Setup bit 26 selects the capture edge: 0 means rising, 1 means falling. Each captured bit shifts in at bit 0 of the response and older bits move up. The response keeps the last 24 bits and is cleared at the start of a transfer.
- R7: The chip-select pin is driven low for the whole transfer. It is released one half-period after the last falling clock edge.
- R8: Outputs are enabled only during a transfer, and only on the clock, data-out and chip-select pins of the active setup. The data-in pin is never enabled. Setup fields are clock [4:0], data-out [9:5], data-in [14:10] and chip-select [19:15].
- R9: A write to 0x14 while ready is low is ignored. The running transfer and its response are not changed.
- R10: When the selected setup has length 0 (bits [25:20]), a data write starts nothing. Ready stays high and no line is enabled.
- R11: Transaction bits [17:16] select the setup and bits [15:0] hold the divider. Both, together with the setup, are captured when the transfer starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| gpio_in | input | 32 | Input levels of the GPIO bank |
| gpio_out | output | 32 | Output values for the GPIO bank |
| gpio_oe | output | 32 | Output enables for the GPIO bank |

## Verification
The assertions assume that every register write is a single-cycle strobe with a word-aligned address. They also assume that the data-in line delivers a known level in every cycle of a transfer. The bench drives writes as one-cycle pulses at falling clock edges and uses only aligned offsets. It feeds the data-in pin of the active setup from that setup's data-out pin, so the input is always defined and the expected response follows from the written word and the edge settings. Setup and transaction registers are rewritten only while ready is high, except in the one test where a data write is deliberately issued mid-transfer.

// File: rtl/gspi_pkg.sv
package gspi_pkg;

   localparam int PIN_W = 5;
   localparam int LEN_W = 6;
   localparam int CFG_W = 4 * PIN_W + LEN_W + 2;

   localparam int WORD_XACT = 4;
   localparam int WORD_DATA = 5;
   localparam int WORD_STAT = 6;
   localparam int READY_BIT = 24;
   localparam int SEL_LSB   = 16;

   typedef struct packed {
      logic             dout_rise;
      logic             din_fall;
      logic [LEN_W-1:0] nbits;
      logic [PIN_W-1:0] sel_pin;
      logic [PIN_W-1:0] din_pin;
      logic [PIN_W-1:0] dout_pin;
      logic [PIN_W-1:0] sck_pin;
   } slot_cfg_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_TAIL  = 2'd2
   } eng_state_t;

endpackage

// File: rtl/gspi_regs.sv
module gspi_regs
   import gspi_pkg::*;
#(
   parameter int NUM_SLOTS = 4,
   parameter int DIV_W     = 16,
   parameter int RESP_W    = 24,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              eng_ready,
   input  logic [RESP_W-1:0] eng_resp,
   output slot_cfg_t         sel_cfg,
   output logic [DIV_W-1:0]  div_val,
   output logic              start_req
);

   localparam int SEL_W  = $clog2(NUM_SLOTS);
   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   logic [1:0]        unused_addr;
   logic [DATA_W-1:CFG_W] unused_wdata;
   slot_cfg_t         slot_view [NUM_SLOTS];
   logic [SEL_W-1:0]  sel_q;
   logic [DIV_W-1:0]  div_q;

   assign word         = reg_addr[ADDR_W-1:2];
   assign unused_addr  = reg_addr[1:0];
   assign unused_wdata = reg_wdata[DATA_W-1:CFG_W];

   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      slot_cfg_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (reg_wr && word == WORD_W'(k)) begin
            q <= slot_cfg_t'(reg_wdata[CFG_W-1:0]);
         end
      end
      assign slot_view[k] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         div_q <= '0;
      end else if (reg_wr && word == WORD_W'(WORD_XACT)) begin
         sel_q <= reg_wdata[SEL_LSB +: SEL_W];
         div_q <= reg_wdata[DIV_W-1:0];
      end
   end

   assign start_req = reg_wr && (word == WORD_W'(WORD_DATA));
   assign sel_cfg   = slot_view[sel_q];
   assign div_val   = div_q;

   always_comb begin
      reg_rdata = '0;
      if (int'(word) < NUM_SLOTS) begin
         reg_rdata[CFG_W-1:0] = slot_view[word[SEL_W-1:0]];
      end else if (word == WORD_W'(WORD_XACT)) begin
         reg_rdata[DIV_W-1:0]         = div_q;
         reg_rdata[SEL_LSB +: SEL_W]  = sel_q;
      end else if (word == WORD_W'(WORD_STAT)) begin
         reg_rdata[RESP_W-1:0] = eng_resp;
         reg_rdata[READY_BIT]  = eng_ready;
      end
   end

   AST_XACT_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && word == WORD_W'(WORD_XACT)) |=> div_q == $past(reg_wdata[DIV_W-1:0])) // R11
      else $error("transaction write lost");

endmodule

// File: rtl/gspi_engine.sv
module gspi_engine
   import gspi_pkg::*;
#(
   parameter int DIV_W  = 16,
   parameter int RESP_W = 24,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req,
   input  logic [DATA_W-1:0] start_data,
   input  slot_cfg_t         cfg,
   input  logic [DIV_W-1:0]  div_val,
   input  logic              din,
   output logic              ready,
   output logic              sck,
   output logic              dout,
   output logic [RESP_W-1:0] resp,
   output slot_cfg_t         act_cfg
);

   localparam int TX_W = 2 ** LEN_W;
   localparam int EC_W = LEN_W + 1;

   eng_state_t        state;
   logic [DIV_W-1:0]  cnt;
   logic [DIV_W-1:0]  div_q;
   logic [EC_W-1:0]   edge_cnt;
   logic [EC_W-1:0]   last_edge;
   logic [TX_W-1:0]   tx;
   logic [RESP_W-1:0] rx;
   logic              sck_q;
   logic              rose_once;
   slot_cfg_t         cfg_q;
   logic              go;
   logic              tick;
   logic              launch_now;
   logic              sample_now;

   assign go         = start_req && (state == ST_IDLE) && (cfg.nbits != '0);
   assign tick       = (cnt == div_q);
   assign last_edge  = {cfg_q.nbits, 1'b0} - EC_W'(1);
   assign launch_now = cfg_q.dout_rise ? (!sck_q && rose_once) : sck_q;
   assign sample_now = cfg_q.din_fall ? sck_q : !sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         div_q     <= '0;
         edge_cnt  <= '0;
         tx        <= '0;
         rx        <= '0;
         sck_q     <= 1'b0;
         rose_once <= 1'b0;
         cfg_q     <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (go) begin
                  state     <= ST_SHIFT;
                  cnt       <= '0;
                  div_q     <= div_val;
                  cfg_q     <= cfg;
                  edge_cnt  <= '0;
                  tx        <= TX_W'(start_data) << (TX_W - int'(cfg.nbits));
                  rx        <= '0;
                  sck_q     <= 1'b0;
                  rose_once <= 1'b0;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  cnt      <= '0;
                  sck_q    <= ~sck_q;
                  edge_cnt <= edge_cnt + EC_W'(1);
                  if (launch_now) tx <= tx << 1;
                  if (sample_now) rx <= {rx[RESP_W-2:0], din};
                  if (!sck_q) rose_once <= 1'b1;
                  if (edge_cnt == last_edge) state <= ST_TAIL;
               end else begin
                  cnt <= cnt + DIV_W'(1);
               end
            end
            ST_TAIL: begin
               if (tick) begin
                  state <= ST_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + DIV_W'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign ready   = (state == ST_IDLE);
   assign sck     = sck_q;
   assign dout    = tx[TX_W-1];
   assign resp    = rx;
   assign act_cfg = cfg_q;

   AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_SHIFT) |-> !sck_q) // R4
      else $error("clock not low outside shifting");

   AST_SCK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sck_q) |-> $past(cnt == div_q)) // R4
      else $error("clock toggled off divider tick");

   AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SHIFT) |-> (edge_cnt <= last_edge)) // R4
      else $error("edge count beyond length");

   AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> !ready) // R3
      else $error("ready still high after start");

   AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !ready) |=> ($stable(cfg_q) && $stable(div_q))) // R9
      else $error("busy write changed transfer");

   AST_ZERO_LEN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && ready && cfg.nbits == '0) |=> ready) // R10
      else $error("zero length started a transfer");

endmodule

// File: rtl/gspi_pinmux.sv
module gspi_pinmux
   import gspi_pkg::*;
#(
   parameter int NUM_GPIO = 32
) (
   input  logic                active,
   input  slot_cfg_t           cfg,
   input  logic                sck,
   input  logic                dout,
   input  logic [NUM_GPIO-1:0] gpio_in,
   output logic [NUM_GPIO-1:0] gpio_out,
   output logic [NUM_GPIO-1:0] gpio_oe,
   output logic                din
);

   for (genvar i = 0; i < NUM_GPIO; i++) begin : g_pin
      logic hit_sel, hit_sck, hit_dout, hit_din;
      assign hit_sel  = (cfg.sel_pin  == PIN_W'(i));
      assign hit_sck  = (cfg.sck_pin  == PIN_W'(i));
      assign hit_dout = (cfg.dout_pin == PIN_W'(i));
      assign hit_din  = (cfg.din_pin  == PIN_W'(i));
      assign gpio_oe[i]  = active && !hit_din && (hit_sel || hit_sck || hit_dout);
      assign gpio_out[i] = hit_sel ? 1'b0 : (hit_sck ? sck : (hit_dout && dout));
   end

   assign din = (int'(cfg.din_pin) < NUM_GPIO) ? gpio_in[cfg.din_pin] : 1'b0;

endmodule

// File: rtl/gpio_spi_master.sv
module gpio_spi_master
   import gspi_pkg::*;
#(
   parameter int NUM_GPIO  = 32,
   parameter int NUM_SLOTS = 4,
   parameter int DIV_W     = 16,
   parameter int RESP_W    = 24,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic [NUM_GPIO-1:0] gpio_in,
   output logic [NUM_GPIO-1:0] gpio_out,
   output logic [NUM_GPIO-1:0] gpio_oe
);

   if (NUM_GPIO < 2 || NUM_GPIO > 2 ** PIN_W) begin : g_bad_gpio
      $error("NUM_GPIO must lie in 2..32");
   end
   if (NUM_SLOTS != 2 && NUM_SLOTS != 4) begin : g_bad_slots
      $error("NUM_SLOTS must be 2 or 4");
   end
   if (DIV_W < 1 || DIV_W > SEL_LSB) begin : g_bad_div
      $error("DIV_W must lie in 1..16");
   end
   if (RESP_W < 2 || RESP_W > READY_BIT) begin : g_bad_resp
      $error("RESP_W must lie in 2..24");
   end
   if (DATA_W != 32 || ADDR_W < 5) begin : g_bad_bus
      $error("bus must be 32 bits wide with at least 5 address bits");
   end

   slot_cfg_t         sel_cfg;
   slot_cfg_t         act_cfg;
   logic [DIV_W-1:0]  div_val;
   logic              start_req;
   logic              eng_ready;
   logic [RESP_W-1:0] eng_resp;
   logic              sck, dout, din;

   gspi_regs #(
      .NUM_SLOTS (NUM_SLOTS),
      .DIV_W     (DIV_W),
      .RESP_W    (RESP_W),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .eng_ready (eng_ready),
      .eng_resp  (eng_resp),
      .sel_cfg   (sel_cfg),
      .div_val   (div_val),
      .start_req (start_req)
   );

   gspi_engine #(
      .DIV_W  (DIV_W),
      .RESP_W (RESP_W),
      .DATA_W (DATA_W)
   ) i_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_req  (start_req),
      .start_data (reg_wdata),
      .cfg        (sel_cfg),
      .div_val    (div_val),
      .din        (din),
      .ready      (eng_ready),
      .sck        (sck),
      .dout       (dout),
      .resp       (eng_resp),
      .act_cfg    (act_cfg)
   );

   gspi_pinmux #(
      .NUM_GPIO (NUM_GPIO)
   ) i_pinmux (
      .active   (!eng_ready),
      .cfg      (act_cfg),
      .sck      (sck),
      .dout     (dout),
      .gpio_in  (gpio_in),
      .gpio_out (gpio_out),
      .gpio_oe  (gpio_oe),
      .din      (din)
   );

   AST_IDLE_RELEASES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
      eng_ready |-> (gpio_oe == '0)) // R8
      else $error("pins driven while idle");

   AST_DIN_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_ready |-> !gpio_oe[act_cfg.din_pin]) // R8
      else $error("data-in pin driven");

   AST_ENABLES_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gpio_oe) <= 3) // R8
      else $error("more than three pins enabled");

   AST_SEL_LOW_ON_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (!eng_ready && act_cfg.sel_pin != act_cfg.din_pin)
         |-> (gpio_oe[act_cfg.sel_pin] && !gpio_out[act_cfg.sel_pin])) // R7
      else $error("chip-select not low during transfer");

endmodule

// File: tb/test_gpio_spi_master.sv
module test_gpio_spi_master;

   typedef struct packed {
      logic [1:0]  slot;
      logic [15:0] div;
      logic [5:0]  len;
      logic        dout_rise;
      logic        din_fall;
      logic [31:0] data;
      logic [23:0] expect_rx;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 16'd0, 6'd8,  1'b0, 1'b0, 32'h0000_00A5, 24'h0000A5},
      '{2'd1, 16'd2, 6'd8,  1'b1, 1'b0, 32'h0000_00A5, 24'h0000D2},
      '{2'd2, 16'd1, 6'd24, 1'b0, 1'b1, 32'h0012_3456, 24'h123456},
      '{2'd3, 16'd0, 6'd4,  1'b1, 1'b1, 32'hFFFF_FFF9, 24'h000009},
      '{2'd0, 16'd3, 6'd30, 1'b0, 1'b0, 32'h3FFF_0F0F, 24'hFF0F0F},
      '{2'd1, 16'd0, 6'd1,  1'b1, 1'b0, 32'h0000_0001, 24'h000001},
      '{2'd2, 16'd0, 6'd40, 1'b0, 1'b1, 32'hCAFE_1234, 24'hFE1234}
   };

   localparam int SCKP [4] = '{3, 0, 10, 30};
   localparam int DOUTP[4] = '{7, 1, 11, 29};
   localparam int DINP [4] = '{12, 2, 5, 28};
   localparam int SELP [4] = '{20, 31, 6, 27};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] gpio_in;
   logic [31:0] gpio_out;
   logic [31:0] gpio_oe;

   int cur = 0;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   always_comb begin
      gpio_in = '0;
      gpio_in[DINP[cur]] = gpio_out[DOUTP[cur]];
   end

   gpio_spi_master i_gpio_spi_master (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .gpio_in   (gpio_in),
      .gpio_out  (gpio_out),
      .gpio_oe   (gpio_oe)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   function automatic logic [31:0] slot_word(input int s, input logic [5:0] len,
                                             input logic dr, input logic df);
      return {4'b0, dr, df, len, 5'(SELP[s]), 5'(DINP[s]), 5'(DOUTP[s]), 5'(SCKP[s])};
   endfunction

   task automatic run_vec(input vec_t v);
      logic [31:0] st;
      logic [31:0] mask;
      int cyc, rises, oe_err, sel_err;
      logic prev_sck;
      cur = int'(v.slot);
      mask = (32'd1 << SCKP[cur]) | (32'd1 << DOUTP[cur]) | (32'd1 << SELP[cur]);
      wr(8'(4 * cur), slot_word(cur, v.len, v.dout_rise, v.din_fall));
      wr(8'h10, {14'd0, v.slot, v.div});
      wr(8'h14, v.data);
      cyc = 0; rises = 0; oe_err = 0; sel_err = 0;
      prev_sck = 1'b0;
      rd(8'h18, st);
      while (!st[24] && cyc < 20000) begin
         if (gpio_oe != mask) oe_err++;
         if (gpio_out[SELP[cur]] !== 1'b0) sel_err++;
         if (gpio_out[SCKP[cur]] && !prev_sck) rises++;
         prev_sck = gpio_out[SCKP[cur]];
         @(posedge clk);
         @(negedge clk);
         cyc++;
         rd(8'h18, st);
      end
      check(cyc == (2 * int'(v.len) + 1) * (int'(v.div) + 1), "R3 busy cycles",
            cyc, (2 * int'(v.len) + 1) * (int'(v.div) + 1));
      check(rises == int'(v.len), "R4 clock rising edges", rises, v.len);
      check(oe_err == 0, "R8 enable mask during transfer", oe_err, 0);
      check(sel_err == 0, "R7 chip-select low", sel_err, 0);
      check(st[23:0] == v.expect_rx, "R5 R6 response bits", st[23:0], v.expect_rx);
      check(st[31:25] == 7'd0 && gpio_oe == '0, "R2 R8 idle after done",
            {st[31:25], gpio_oe}, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d;
      int errs;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state
      rd(8'h18, d);
      check(d == 32'h0100_0000, "R2 status after reset", d, 32'h0100_0000);
      rd(8'h00, d);
      check(d == 32'd0, "R1 slot0 after reset", d, 0);
      rd(8'h10, d);
      check(d == 32'd0, "R11 transaction after reset", d, 0);
      check(gpio_oe == '0, "R8 no enables after reset", gpio_oe, 0);

      // R1 readback masks
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h08, d);
      check(d == 32'h0FFF_FFFF, "R1 slot2 readback", d, 32'h0FFF_FFFF);
      wr(8'h10, 32'hFFFF_FFFF);
      rd(8'h10, d);
      check(d == 32'h0003_FFFF, "R1 transaction readback", d, 32'h0003_FFFF);
      rd(8'h0C, d);
      check(d == 32'd0, "R1 slot3 untouched", d, 0);
      check(gpio_oe == '0, "R8 config writes drive nothing", gpio_oe, 0);

      // vector table
      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R9 data write while busy
      cur = 0;
      wr(8'h00, slot_word(0, 6'd8, 1'b0, 1'b0));
      wr(8'h10, 32'h0000_0001);
      wr(8'h14, 32'h0000_00A5);
      repeat (3) @(negedge clk);
      wr(8'h14, 32'h0000_005A);
      rd(8'h18, d);
      while (!d[24]) begin
         @(negedge clk);
         rd(8'h18, d);
      end
      check(d[23:0] == 24'hA5, "R9 busy write ignored response", d[23:0], 24'hA5);
      errs = 0;
      repeat (10) begin
         @(negedge clk);
         rd(8'h18, d);
         if (!d[24] || gpio_oe != '0) errs++;
      end
      check(errs == 0, "R9 no second transfer", errs, 0);

      // R10 zero length
      wr(8'h04, slot_word(1, 6'd0, 1'b0, 1'b0));
      wr(8'h10, 32'h0001_0000);
      wr(8'h14, 32'hFFFF_FFFF);
      errs = 0;
      repeat (20) begin
         rd(8'h18, d);
         if (!d[24] || gpio_oe != '0 || gpio_out[SCKP[1]]) errs++;
         @(negedge clk);
      end
      check(errs == 0, "R10 zero length no activity", errs, 0);
      rd(8'h18, d);
      check(d[23:0] == 24'hA5, "R10 response kept", d[23:0], 24'hA5);

      // R11 select picks a different slot's pins
      run_vec('{2'd3, 16'd1, 6'd3, 1'b0, 1'b0, 32'h0000_0006, 24'h000006});

      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule